// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences a small processor into and out of its low-power sleep state. A one-cycle strobe from instruction decode asks for sleep. The controller then stops the oscillator driver, freezes the I/O pins in their present drive state, halts the core and updates two status flags. Software reads these flags after resuming to learn why the core woke. If the watchdog is enabled, the watchdog counter gets a one-cycle clear pulse as sleep begins, and it keeps running during sleep.

Two kinds of event wake the block. The first is any peripheral interrupt request whose enable bit is set. The second is a watchdog time-out, which during sleep causes a wake and not a full reset. The oscillator driver is switched back on in the cycle after the wake event. In the three crystal modes the core then stays halted until a parameterised number of oscillator cycles has passed, so the crystal can settle. In RC mode the core resumes at once. The I/O hold is released in the same cycle the core resumes. A sleep strobe that arrives while a wake request is already pending is dropped, and the core keeps running.

Top module: `slp_ctrl`

## Requirements
- R1: After synchronous reset, the outputs are: osc_en=1, io_hold=0, core_run=1, flag_to=1, flag_pd=1, wdt_clr=0.
- R2: A sleep strobe while running, with no wake request pending, gives these outputs one cycle later: osc_en=0, io_hold=1, core_run=0, flag_pd=0, flag_to=1.
- R3: On sleep entry, wdt_clr is high for exactly the one cycle after the strobe when wdt_enable=1. It stays low when wdt_enable=0.
- R4: The block enters sleep only on the strobe. A strobe that arrives while asleep or while waiting for the oscillator has no effect on the outputs or on the restart timing.
- R5: A request on irq_req[i] wakes the block only while irq_en[i]=1. Requests whose enable bit is clear leave the block asleep.
- R6: A watchdog time-out during sleep wakes the block and clears flag_to one cycle later. An interrupt-only wake leaves flag_to at 1.
- R7: osc_en returns to 1 in the cycle after the wake event. io_hold stays 1 until core_run rises, and falls in that same cycle.
- R8: osc_mode codes 0, 1 and 2 are the low-power, standard and high-speed crystal modes. In these modes core_run rises exactly OST_CYCLES cycles after osc_en rises. With osc_mode=3 (RC), core_run rises in the same cycle as osc_en.
- R9: A sleep strobe that arrives while an enabled interrupt or a watchdog time-out is present is ignored. The outputs stay as they were and no wdt_clr pulse is made.
- R10: flag_pd stays 0 after a wake until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep strobe from instruction decode |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_en | input | N_IRQ | Per-request wake enable mask |
| wdt_enable | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| osc_mode | input | 2 | Oscillator mode: 0 low-power crystal, 1 crystal, 2 high-speed crystal, 3 RC |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| io_hold | output | 1 | Freeze I/O pin drive state |
| flag_to | output | 1 | Time-out status flag (0 after a watchdog wake) |
| flag_pd | output | 1 | Power-down status flag (0 after sleep entry) |
| core_run | output | 1 | Core allowed to execute |

## Verification
A table of sleep-then-wake scenarios is run under every oscillator mode. Each scenario sets a different pairing of request vector and enable mask, with and without a watchdog time-out. The bench measures the exact cycle in which core_run returns, which shows whether the crystal delay is applied or bypassed. The flag_to value after the wake shows whether the wake came from the watchdog or from an interrupt. Masked-only requests must leave the block asleep, which checks that the enable mask actually gates the wake. Directed tests cover a strobe while a wake is pending, a strobe while asleep, and a strobe during the oscillator restart, which must not shorten or restart the delay.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_RESTART = 2'd2
    } slp_state_e;

    typedef struct packed {
        logic osc_en;
        logic io_hold;
        logic core_run;
    } pwr_ctl_t;

    function automatic logic needs_settle(osc_mode_e m);
        return (m != OSC_RC);
    endfunction

    function automatic pwr_ctl_t decode_state(slp_state_e s);
        pwr_ctl_t c;
        c.osc_en   = (s != ST_SLEEP);
        c.io_hold  = (s != ST_RUN);
        c.core_run = (s == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             wake_any,
    output logic             wake_wdt
);
    logic [N_IRQ-1:0] gated;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_gate
        assign gated[i] = irq_req[i] & irq_en[i];
    end

    assign wake_wdt = wdt_timeout;
    assign wake_any = (|gated) | wdt_timeout;
endmodule

// File: rtl/slp_osc_timer.sv
module slp_osc_timer #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == LAST) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = active_q && (cnt_q == LAST);
endmodule

// File: rtl/slp_status_flags.sv
module slp_status_flags (
    input  logic clk,
    input  logic rst,
    input  logic enter_sleep,
    input  logic wdt_wake,
    output logic flag_to,
    output logic flag_pd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_to <= 1'b1;
            flag_pd <= 1'b1;
        end else begin
            if (enter_sleep) begin
                flag_to <= 1'b1;
                flag_pd <= 1'b0;
            end else if (wdt_wake) begin
                flag_to <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int OST_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_enable,
    input  logic             wdt_timeout,
    input  logic [1:0]       osc_mode,
    output logic             osc_en,
    output logic             wdt_clr,
    output logic             io_hold,
    output logic             flag_to,
    output logic             flag_pd,
    output logic             core_run
);
    slp_state_e state_q, state_d;
    pwr_ctl_t   ctl;
    logic       wake_any, wake_wdt;
    logic       enter_sleep, wake_now, settle_start, settle_done;
    logic       wdt_clr_q;

    slp_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .wake_any    (wake_any),
        .wake_wdt    (wake_wdt)
    );

    assign enter_sleep  = (state_q == ST_RUN) && sleep_req && !wake_any;
    assign wake_now     = (state_q == ST_SLEEP) && wake_any;
    assign settle_start = wake_now && needs_settle(osc_mode_e'(osc_mode));

    slp_osc_timer #(.OST_CYCLES(OST_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (settle_start),
        .done  (settle_done)
    );

    slp_status_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .enter_sleep (enter_sleep),
        .wdt_wake    (wake_now && wake_wdt),
        .flag_to     (flag_to),
        .flag_pd     (flag_pd)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (enter_sleep) state_d = ST_SLEEP;
            ST_SLEEP:   if (wake_now) state_d = settle_start ? ST_RESTART : ST_RUN;
            ST_RESTART: if (settle_done) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_RUN;
            wdt_clr_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            wdt_clr_q <= enter_sleep && wdt_enable;
        end
    end

    assign ctl      = decode_state(state_q);
    assign osc_en   = ctl.osc_en;
    assign io_hold  = ctl.io_hold;
    assign core_run = ctl.core_run;
    assign wdt_clr  = wdt_clr_q;
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_req,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             wdt_enable,
    input logic             wdt_timeout,
    input logic [1:0]       osc_mode,
    input logic             osc_en,
    input logic             wdt_clr,
    input logic             io_hold,
    input logic             flag_to,
    input logic             flag_pd,
    input logic             core_run
);
    logic pend;
    assign pend = (|(irq_req & irq_en)) | wdt_timeout;

    a_r2_enter_sleep: assert property (@(posedge clk) disable iff (rst)
        core_run && sleep_req && !pend |=> !osc_en && io_hold && !core_run && !flag_pd && flag_to);

    a_r3_clr_origin: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |-> $past(sleep_req) && $past(wdt_enable) && !core_run);

    a_r4_stay_asleep: assert property (@(posedge clk) disable iff (rst)
        !osc_en && !pend |=> !osc_en);

    a_r5_wake_on_enabled: assert property (@(posedge clk) disable iff (rst)
        !osc_en && pend |=> osc_en);

    a_r6_wdt_clears_to: assert property (@(posedge clk) disable iff (rst)
        !osc_en && wdt_timeout |=> !flag_to);

    a_r7_hold_while_off: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> io_hold && !core_run);

    a_r7_release_with_run: assert property (@(posedge clk) disable iff (rst)
        $fell(io_hold) |-> $rose(core_run));

    a_r9_skip_when_pending: assert property (@(posedge clk) disable iff (rst)
        core_run && sleep_req && pend |=> core_run && osc_en && !wdt_clr);

    a_r10_pd_sticky: assert property (@(posedge clk) disable iff (rst)
        !flag_pd |=> !flag_pd);
endmodule

bind slp_ctrl slp_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/slp_ctrl_test.sv
`timescale 1ns/1ps
module slp_ctrl_test;
    localparam int N_IRQ = 4;
    localparam int OST   = 1024;
    localparam int NV    = 8;

    typedef struct packed {
        logic [1:0] mode;
        logic       wdt_en;
        logic [3:0] req;
        logic [3:0] en;
        logic       wdt_to;
        logic       exp_wake;
        logic       exp_to;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 4'b0001, 4'b0001, 1'b0, 1'b1, 1'b1},
        '{2'd1, 1'b0, 4'b0100, 4'b0110, 1'b0, 1'b1, 1'b1},
        '{2'd2, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0},
        '{2'd3, 1'b1, 4'b1000, 4'b1000, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0},
        '{2'd1, 1'b1, 4'b0011, 4'b1100, 1'b0, 1'b0, 1'b1},
        '{2'd2, 1'b0, 4'b1111, 4'b0000, 1'b0, 1'b0, 1'b1},
        '{2'd0, 1'b1, 4'b1010, 4'b0010, 1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, sleep_req, wdt_enable, wdt_timeout;
    logic [N_IRQ-1:0] irq_req, irq_en;
    logic [1:0] osc_mode;
    logic osc_en, wdt_clr, io_hold, flag_to, flag_pd, core_run;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    slp_ctrl #(.N_IRQ(N_IRQ), .OST_CYCLES(OST)) uut (.*);

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            summary();
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sleep_req = 0; irq_req = '0; irq_en = '0;
        wdt_timeout = 0; wdt_enable = 0; osc_mode = 2'd0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        tick(3);
        rst = 0;
    endtask

    task automatic enter_sleep(input logic wen);
        wdt_enable = wen;
        sleep_req = 1;
        tick();
        sleep_req = 0;
    endtask

    function automatic int pack_out();
        return {osc_en, io_hold, core_run, flag_to, flag_pd, wdt_clr};
    endfunction

    initial begin
        int n;
        idle_inputs();
        rst = 1;
        tick(3);

        // R1: reset state
        chk("R1 osc_en", osc_en, 1);
        chk("R1 io_hold", io_hold, 0);
        chk("R1 core_run", core_run, 1);
        chk("R1 flag_to", flag_to, 1);
        chk("R1 flag_pd", flag_pd, 1);
        chk("R1 wdt_clr", wdt_clr, 0);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            osc_mode = VEC[v].mode;
            enter_sleep(VEC[v].wdt_en);
            chk("R2 osc_en off", osc_en, 0);
            chk("R2 io_hold on", io_hold, 1);
            chk("R2 core stopped", core_run, 0);
            chk("R2 flag_pd", flag_pd, 0);
            chk("R2 flag_to", flag_to, 1);
            chk("R3 wdt_clr pulse", wdt_clr, int'(VEC[v].wdt_en));
            tick();
            chk("R3 wdt_clr one cycle", wdt_clr, 0);
            irq_req = VEC[v].req;
            irq_en  = VEC[v].en;
            wdt_timeout = VEC[v].wdt_to;
            tick();
            if (!VEC[v].exp_wake) begin
                tick(3);
                chk("R5 masked stays asleep", osc_en, 0);
                sleep_req = 1;
                tick();
                sleep_req = 0;
                // R4: strobe while asleep changes nothing
                chk("R4 strobe asleep", pack_out(), 6'b010100);
                continue;
            end
            irq_req = '0; irq_en = '0; wdt_timeout = 0;
            chk("R7 osc_en back", osc_en, 1);
            chk("R6 flag_to after wake", flag_to, int'(VEC[v].exp_to));
            n = 0;
            while (!core_run && n < OST + 10) begin
                chk("R7 io_hold held", io_hold, 1);
                tick();
                n++;
            end
            chk("R8 restart delay", n, (VEC[v].mode == 2'd3) ? 0 : OST);
            chk("R7 io_hold released", io_hold, 0);
            chk("R10 flag_pd stays 0", flag_pd, 0);
            chk("R6 flag_to kept", flag_to, int'(VEC[v].exp_to));
        end

        // R9: strobe with enabled request pending is skipped
        do_reset();
        irq_req = 4'b0010; irq_en = 4'b0010;
        enter_sleep(1'b1);
        chk("R9 skip outputs", pack_out(), 6'b101110);
        irq_req = '0; irq_en = '0;
        tick();
        chk("R9 no clr", wdt_clr, 0);

        // R9: pending watchdog time-out also skips
        wdt_timeout = 1;
        enter_sleep(1'b1);
        wdt_timeout = 0;
        chk("R9 wdt pending skip", pack_out(), 6'b101110);

        // R4: no strobe, no sleep
        tick(5);
        chk("R4 no strobe", pack_out(), 6'b101110);

        // R4: strobe during restart neither stops nor re-times it
        do_reset();
        osc_mode = 2'd1;
        enter_sleep(1'b0);
        irq_req = 4'b0001; irq_en = 4'b0001;
        tick();
        irq_req = '0; irq_en = '0;
        tick(5);
        sleep_req = 1;
        tick();
        sleep_req = 0;
        chk("R4 strobe in restart osc", osc_en, 1);
        n = 6;
        while (!core_run && n < OST + 10) begin
            tick();
            n++;
        end
        chk("R4 restart timing kept", n, OST);

        // R10: pd only returns to 1 by reset
        tick(4);
        chk("R10 pd still 0", flag_pd, 0);
        do_reset();
        chk("R1 pd after reset", flag_pd, 1);

        summary();
    end
endmodule